// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block keeps a small, fully associative set of recent page translations, each mapping a virtual page number to a physical frame number together with access attributes (three permission bits, a user-access bit and a modified bit). Every stored translation is tagged with the process context that was active when it was installed. A lookup only hits when both the page number and the tag equal the requested page and the currently active context. This lets translations belonging to several processes sit side by side, and a context switch costs nothing.

On a lookup miss, an external page walker resolves the translation and installs it through the fill port. The fill is tagged with the active context. Control inputs change the active context, remove every entry of one context, or remove all entries. Two free-running counters record hits and misses so that a hit rate can be measured. The block only passes the attribute bits through; it does not check them.

Top module: `ctx_tlb`

## Requirements
- R1: After synchronous reset: every entry is invalid, `lk_valid` is 0, both counters are 0 and `active_ctx` is 0.
- R2: A lookup strobe in cycle N gives `lk_valid`=1 in cycle N+1 with `lk_hit` and, on a hit, the stored frame, `lk_perm[2:0]`, `lk_user` and `lk_dirty` exactly as filled. With no strobe in cycle N, `lk_valid` is 0 in cycle N+1.
- R3: A hit needs a valid entry whose page number equals `lk_vpn` and whose context tag equals `active_ctx`. The same page filled under another context does not hit.
- R4: Changing the active context invalidates nothing. Switching back to an earlier context hits its old translations again.
- R5: A fill whose page and active context match an existing valid entry overwrites that entry in place, so no two valid entries ever match the same page and context. A later lookup returns the new frame.
- R6: A fill that matches no entry uses the lowest-numbered invalid entry. When all entries are valid, it replaces a round-robin victim: after reset the pointer is at entry 0, and it advances by one (wrapping) only on each such replacement. Flushes do not move it.
- R7: `flush_all` invalidates every entry of every context from the next cycle on.
- R8: `flush_ctx` invalidates in one cycle exactly the entries tagged `flush_ctx_id`. Entries of other contexts are kept.
- R9: A fill and a lookup of the same page in the same cycle give a miss. The new translation hits from the next cycle.
- R10: Each lookup strobe adds one to `hit_count` on a hit or to `miss_count` on a miss. The counter update is visible in the same cycle as `lk_valid`.
- R11: `ctx_set` loads `ctx_id_in` into `active_ctx` at the clock edge. Lookups and fills in the same cycle still use the old context.
- R12: A fill in a cycle where `flush_all` or `flush_ctx` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_valid | output | 1 | Lookup response valid |
| lk_hit | output | 1 | Response is a hit |
| lk_pfn | output | PFN_W | Frame number on hit |
| lk_perm | output | 3 | Permission bits on hit |
| lk_user | output | 1 | User-access bit on hit |
| lk_dirty | output | 1 | Modified bit on hit |
| fill_req | input | 1 | Install a translation under the active context |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | 3 | Permission bits to install |
| fill_user | input | 1 | User-access bit to install |
| fill_dirty | input | 1 | Modified bit to install |
| ctx_set | input | 1 | Load a new active context |
| ctx_id_in | input | CID_W | New active context |
| flush_all | input | 1 | Invalidate all entries |
| flush_ctx | input | 1 | Invalidate entries of one context |
| flush_ctx_id | input | CID_W | Context to invalidate |
| active_ctx | output | CID_W | Current active context |
| hit_count | output | CNT_W | Lookup hits since reset |
| miss_count | output | CNT_W | Lookup misses since reset |

## Verification
The assertions check on every cycle that a lookup strobe gets a response exactly one cycle later and that an idle cycle gets none. They also check that at most one valid entry matches a lookup, that a global flush leaves no valid entry, that the active context moves only when it is loaded, and that the two counters together advance by exactly one per strobe. The scenarios are needed for the rest. Only they can show context isolation and coexistence, the choice between an invalid slot and the round-robin victim, and the effect of a per-context flush on the entries it keeps. They also cover the same-cycle conflicts: a fill racing a lookup, a context load racing a lookup, and a fill dropped by a flush.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  typedef struct packed {
    logic [2:0] perm;
    logic       user;
    logic       dirty;
  } tlb_attr_t;
endpackage

// File: rtl/ctx_tlb_store.sv
module ctx_tlb_store
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int CID_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [CID_W-1:0]   cur_cid,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  tlb_attr_t          wr_attr,
  input  logic               clr_all,
  input  logic               clr_ctx,
  input  logic [CID_W-1:0]   clr_ctx_id,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] wr_match_vec,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn,
  output tlb_attr_t          lk_attr
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [CID_W-1:0]   cid_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  tlb_attr_t          attr_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match;

  // valid bits: reset and flushes take priority over the write
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (clr_all)
          vld_q[i] <= 1'b0;
        else if (clr_ctx && (cid_q[i] == clr_ctx_id))
          vld_q[i] <= 1'b0;
        else if (wr_en && (wr_idx == IDX_W'(i)))
          vld_q[i] <= 1'b1;
      end
    end
  end

  // payload: single write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      cid_q[wr_idx]  <= cur_cid;
      pfn_q[wr_idx]  <= wr_pfn;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]     = vld_q[g] && (vpn_q[g] == lk_vpn) && (cid_q[g] == cur_cid);
    assign wr_match_vec[g] = vld_q[g] && (vpn_q[g] == wr_vpn) && (cid_q[g] == cur_cid);
  end

  always_comb begin
    lk_hit  = |lk_match;
    lk_pfn  = '0;
    lk_attr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        lk_pfn  = pfn_q[i];
        lk_attr = attr_q[i];
      end
    end
  end

  assign valid_vec = vld_q;

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match)); // R5
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (vld_q == '0)); // R7
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   sel_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_match;
  logic             all_valid;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i])  match_idx = IDX_W'(i);
      if (!valid_vec[i]) free_idx  = IDX_W'(i);
    end
  end

  assign any_match = |match_vec;
  assign all_valid = &valid_vec;
  assign sel_idx   = any_match ? match_idx : (all_valid ? rr_q : free_idx);

  always_ff @(posedge clk) begin
    if (rst)
      rr_q <= '0;
    else if (fire && !any_match && all_valid)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  AST_RR_STILL_UNLESS_EVICT: assert property (@(posedge clk) disable iff (rst)
    !(fire && all_valid && !any_match) |=> $stable(rr_q)); // R6
endmodule

// File: rtl/ctx_tlb_stats.sv
module ctx_tlb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             hit,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (strobe) begin
      if (hit) hit_cnt  <= hit_cnt + 1'b1;
      else     miss_cnt <= miss_cnt + 1'b1;
    end
  end

  AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (CNT_W'(hit_cnt - $past(hit_cnt)) + CNT_W'(miss_cnt - $past(miss_cnt)) == CNT_W'(1))); // R10
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(hit_cnt) && $stable(miss_cnt))); // R10
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int CID_W   = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_valid,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [2:0]       lk_perm,
  output logic             lk_user,
  output logic             lk_dirty,
  input  logic             fill_req,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm,
  input  logic             fill_user,
  input  logic             fill_dirty,
  input  logic             ctx_set,
  input  logic [CID_W-1:0] ctx_id_in,
  input  logic             flush_all,
  input  logic             flush_ctx,
  input  logic [CID_W-1:0] flush_ctx_id,
  output logic [CID_W-1:0] active_ctx,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [CID_W-1:0]   cid_q;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] wr_match_vec;
  logic               cmp_hit;
  logic [PFN_W-1:0]   cmp_pfn;
  tlb_attr_t          cmp_attr;
  tlb_attr_t          fill_attr;
  logic               rsp_vld_q;
  logic               rsp_hit_q;
  logic [PFN_W-1:0]   rsp_pfn_q;
  tlb_attr_t          rsp_attr_q;

  assign fill_attr = '{perm: fill_perm, user: fill_user, dirty: fill_dirty};
  assign wr_en     = fill_req && !flush_all && !flush_ctx;

  always_ff @(posedge clk) begin
    if (rst)          cid_q <= '0;
    else if (ctx_set) cid_q <= ctx_id_in;
  end

  ctx_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CID_W(CID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .lk_vpn(lk_vpn), .cur_cid(cid_q),
    .wr_vpn(fill_vpn), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_pfn(fill_pfn), .wr_attr(fill_attr),
    .clr_all(flush_all), .clr_ctx(flush_ctx), .clr_ctx_id(flush_ctx_id),
    .valid_vec(valid_vec), .wr_match_vec(wr_match_vec),
    .lk_hit(cmp_hit), .lk_pfn(cmp_pfn), .lk_attr(cmp_attr)
  );

  ctx_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .fire(wr_en),
    .match_vec(wr_match_vec), .valid_vec(valid_vec), .sel_idx(wr_idx)
  );

  ctx_tlb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .strobe(lk_req), .hit(cmp_hit),
    .hit_cnt(hit_count), .miss_cnt(miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_q  <= 1'b0;
      rsp_hit_q  <= 1'b0;
      rsp_pfn_q  <= '0;
      rsp_attr_q <= '0;
    end else begin
      rsp_vld_q <= lk_req;
      if (lk_req) begin
        rsp_hit_q  <= cmp_hit;
        rsp_pfn_q  <= cmp_hit ? cmp_pfn : '0;
        rsp_attr_q <= cmp_hit ? cmp_attr : '0;
      end
    end
  end

  assign lk_valid   = rsp_vld_q;
  assign lk_hit     = rsp_hit_q;
  assign lk_pfn     = rsp_pfn_q;
  assign lk_perm    = rsp_attr_q.perm;
  assign lk_user    = rsp_attr_q.user;
  assign lk_dirty   = rsp_attr_q.dirty;
  assign active_ctx = cid_q;

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid); // R2
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_valid); // R2
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctx_set |=> $stable(active_ctx)); // R11
  AST_CTX_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctx_set |=> (active_ctx == $past(ctx_id_in))); // R11
endmodule

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;
  localparam logic [2:0] OP_FILL = 3'd0, OP_LOOK = 3'd1, OP_SETC = 3'd2,
                         OP_FLA  = 3'd3, OP_FLC  = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [19:0] a;    // page, or context in the low 8 bits
    logic [19:0] b;    // frame to fill / frame expected
    logic        eh;   // expected hit
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{OP_FILL, 20'h00010, 20'hA001D, 1'b0, 4'd2},
    '{OP_LOOK, 20'h00010, 20'hA001D, 1'b1, 4'd2},  // R2 hit with attributes
    '{OP_LOOK, 20'h00011, 20'h00000, 1'b0, 4'd2},  // R2 miss
    '{OP_SETC, 20'h00005, 20'h00000, 1'b0, 4'd3},
    '{OP_LOOK, 20'h00010, 20'h00000, 1'b0, 4'd3},  // R3 other context misses
    '{OP_FILL, 20'h00010, 20'hB0012, 1'b0, 4'd3},
    '{OP_LOOK, 20'h00010, 20'hB0012, 1'b1, 4'd3},  // R3
    '{OP_SETC, 20'h00000, 20'h00000, 1'b0, 4'd4},
    '{OP_LOOK, 20'h00010, 20'hA001D, 1'b1, 4'd4},  // R4 coexistence
    '{OP_FILL, 20'h00010, 20'hC0007, 1'b0, 4'd5},
    '{OP_LOOK, 20'h00010, 20'hC0007, 1'b1, 4'd5},  // R5 overwrite in place
    '{OP_FLC,  20'h00005, 20'h00000, 1'b0, 4'd8},
    '{OP_SETC, 20'h00005, 20'h00000, 1'b0, 4'd8},
    '{OP_LOOK, 20'h00010, 20'h00000, 1'b0, 4'd8},  // R8 flushed context
    '{OP_SETC, 20'h00000, 20'h00000, 1'b0, 4'd8},
    '{OP_LOOK, 20'h00010, 20'hC0007, 1'b1, 4'd8},  // R8 other context kept
    '{OP_FLA,  20'h00000, 20'h00000, 1'b0, 4'd7},
    '{OP_LOOK, 20'h00010, 20'h00000, 1'b0, 4'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req, lk_valid, lk_hit, lk_user, lk_dirty;
  logic [19:0] lk_vpn, lk_pfn;
  logic [2:0]  lk_perm;
  logic        fill_req, fill_user, fill_dirty;
  logic [19:0] fill_vpn, fill_pfn;
  logic [2:0]  fill_perm;
  logic        ctx_set, flush_all, flush_ctx;
  logic [7:0]  ctx_id_in, flush_ctx_id, active_ctx;
  logic [15:0] hit_count, miss_count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ctx_tlb u_ctx_tlb (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_perm(lk_perm), .lk_user(lk_user), .lk_dirty(lk_dirty),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .fill_user(fill_user), .fill_dirty(fill_dirty),
    .ctx_set(ctx_set), .ctx_id_in(ctx_id_in),
    .flush_all(flush_all), .flush_ctx(flush_ctx), .flush_ctx_id(flush_ctx_id),
    .active_ctx(active_ctx), .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [19:0] pf(input logic [19:0] v);
    return v + 20'h70000;
  endfunction

  task automatic clear_inputs();
    lk_req = 0; fill_req = 0; ctx_set = 0; flush_all = 0; flush_ctx = 0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [19:0] a, input logic [19:0] b);
    case (op)
      OP_FILL: begin
        fill_req = 1; fill_vpn = a; fill_pfn = b;
        fill_perm = b[2:0]; fill_user = b[3]; fill_dirty = b[4];
      end
      OP_LOOK: begin lk_req = 1; lk_vpn = a; end
      OP_SETC: begin ctx_set = 1; ctx_id_in = a[7:0]; end
      OP_FLA:  flush_all = 1;
      OP_FLC:  begin flush_ctx = 1; flush_ctx_id = a[7:0]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [2:0] op, input logic [19:0] a, input logic [19:0] b);
    @(negedge clk); drive(op, a, b);
    @(negedge clk); clear_inputs();
  endtask

  task automatic check(input string tag, input bit eh, input logic [19:0] ep);
    n_chk++;
    if (!lk_valid || lk_hit !== eh ||
        (eh && (lk_pfn !== ep || lk_perm !== ep[2:0] || lk_user !== ep[3] || lk_dirty !== ep[4]))) begin
      n_fail++;
      $display("FAIL %s: valid=%0b hit=%0b pfn=%h attr=%b%b%b expected hit=%0b pfn=%h attr=%b%b%b",
               tag, lk_valid, lk_hit, lk_pfn, lk_perm, lk_user, lk_dirty,
               eh, ep, ep[2:0], ep[3], ep[4]);
    end
  endtask

  task automatic look(input string tag, input logic [19:0] v, input bit eh, input logic [19:0] ep);
    step(OP_LOOK, v, 20'h0);
    check(tag, eh, ep);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_state(input string tag);
    @(negedge clk); rst = 1; clear_inputs();
    repeat (2) @(negedge clk);
    rst = 0;
    check_val({tag, " lk_valid"}, int'(lk_valid), 0);
    check_val({tag, " hit_count"}, int'(hit_count), 0);
    check_val({tag, " miss_count"}, int'(miss_count), 0);
    check_val({tag, " active_ctx"}, int'(active_ctx), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int h0, m0;
    lk_vpn = 0; fill_vpn = 0; fill_pfn = 0; fill_perm = 0; fill_user = 0; fill_dirty = 0;
    ctx_id_in = 0; flush_ctx_id = 0;
    clear_inputs();
    rst = 1;
    reset_state("R1 reset");

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].a, VECS[i].b);
      if (VECS[i].op == OP_LOOK)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eh, VECS[i].b);
    end

    // R6: fill all slots, then round-robin and first-invalid choice
    for (int i = 0; i < 8; i++) step(OP_FILL, 20'h100 + 20'(i), pf(20'h100 + 20'(i)));
    step(OP_FILL, 20'h200, pf(20'h200));        // evicts slot 0
    look("R6 rr victim 0", 20'h100, 1'b0, 20'h0);
    look("R6 neighbour kept", 20'h101, 1'b1, pf(20'h101));
    look("R6 new entry", 20'h200, 1'b1, pf(20'h200));
    step(OP_FILL, 20'h201, pf(20'h201));        // evicts slot 1
    look("R6 rr victim 1", 20'h101, 1'b0, 20'h0);
    look("R6 new entry 2", 20'h201, 1'b1, pf(20'h201));
    step(OP_SETC, 20'h3, 20'h0);
    step(OP_FILL, 20'h300, pf(20'h300));        // evicts slot 2
    step(OP_SETC, 20'h0, 20'h0);
    look("R6 rr victim 2", 20'h102, 1'b0, 20'h0);
    step(OP_FLC, 20'h3, 20'h0);                  // slot 2 invalid again
    step(OP_FILL, 20'h400, pf(20'h400));        // must use slot 2, not slot 3
    look("R6 invalid slot used", 20'h103, 1'b1, pf(20'h103));
    look("R6 filled entry", 20'h400, 1'b1, pf(20'h400));

    // R9: fill and lookup of the same page in one cycle
    @(negedge clk);
    drive(OP_FILL, 20'h500, pf(20'h500));
    drive(OP_LOOK, 20'h500, 20'h0);
    @(negedge clk); clear_inputs();
    check("R9 same-cycle miss", 1'b0, 20'h0);
    look("R9 visible next cycle", 20'h500, 1'b1, pf(20'h500));

    // R11: context load and lookup in one cycle
    @(negedge clk);
    drive(OP_SETC, 20'h9, 20'h0);
    drive(OP_LOOK, 20'h104, 20'h0);
    @(negedge clk); clear_inputs();
    check("R11 old context used", 1'b1, pf(20'h104));
    look("R11 new context active", 20'h104, 1'b0, 20'h0);
    check_val("R11 active_ctx", int'(active_ctx), 9);
    step(OP_SETC, 20'h0, 20'h0);

    // R12: fill dropped when a flush is in the same cycle
    @(negedge clk);
    drive(OP_FILL, 20'h600, pf(20'h600));
    drive(OP_FLC, 20'h77, 20'h0);
    @(negedge clk); clear_inputs();
    look("R12 fill dropped", 20'h600, 1'b0, 20'h0);
    look("R12 others kept", 20'h105, 1'b1, pf(20'h105));

    // R10: counters
    h0 = int'(hit_count); m0 = int'(miss_count);
    look("R10 hit lookup", 20'h104, 1'b1, pf(20'h104));
    check_val("R10 hit_count +1", int'(hit_count), h0 + 1);
    check_val("R10 miss_count same", int'(miss_count), m0);
    look("R10 miss lookup", 20'h999, 1'b0, 20'h0);
    check_val("R10 miss_count +1", int'(miss_count), m0 + 1);
    check_val("R10 hit_count same", int'(hit_count), h0 + 1);

    // R1: reset in the middle of operation
    reset_state("R1 mid-run reset");
    look("R1 entries invalid", 20'h104, 1'b0, 20'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule